// File: doc/BRIEF.md
# Multi-mode output compare unit

This block watches a 16-bit count taken from one of two external timers and drives a single output pin when that count equals one of two compare values. A 3-bit mode field picks the behaviour. The one-shot modes drive the pin high or low once. Toggle mode flips the pin on every match. The delayed one-shot mode produces one pulse that starts on the primary value and ends on the secondary value. The continuous pulse mode repeats that pulse on every timer cycle. There are also two PWM variants. In PWM the period comes from the chosen timer's rollover strobe and the duty comes from the secondary value, which is copied into a duty register at each rollover.

Software writes the compare values, the control field and a flag acknowledge through a small write port. Compare events raise a sticky interrupt flag. In the fault-protected PWM variant, an external fault input forces the pin low and holds it low until the control field is written again. Every output is registered, so each pin, enable and flag change appears one clock after the cycle that caused it.

Top module: `ocmp_unit`

## Requirements
- R1: Control bit 3 picks the time base. 0 selects timer A's count and rollover strobe, and 1 selects timer B's. The unselected timer has no effect on the pin.
- R2: Writes use address 0 for the primary compare value, 1 for the secondary value, 2 for control (bits 2:0 mode, bit 3 time base) and 3 for flag acknowledge. A control write taken on edge k applies its mode's start state on edge k+1. That start state is pin high for mode 010 and pin low otherwise, with the pulse and fault history cleared. A match in a cycle is visible on the pin after the next edge.
- R3: In mode 000 the pin and pin_oe_o are low and compare events raise no flag. In every other mode pin_oe_o is high. Whenever pin_oe_o is low, the pin is low.
- R4: In mode 001 a primary match drives the pin high and it stays high. In mode 010 a primary match drives it low and it stays low.
- R5: In mode 011 each cycle in which the count equals the primary value inverts the pin.
- R6: In mode 100 a primary match drives the pin high and a later secondary match drives it low, only once per control write. In mode 101 the same pulse repeats on every primary/secondary pair.
- R7: In modes 110 and 111 a rollover copies the secondary value into the duty register. It drives the pin high if that value is nonzero and low if it is zero. A count equal to the duty register in a cycle without rollover drives the pin low. A secondary write has no effect until the next rollover. Rollover beats a duty match in the same cycle.
- R8: In mode 111 a high fault input drives the pin low and latches. The pin stays low through later rollovers until the next control write. The fault beats a rollover in the same cycle. Mode 110 ignores the fault input.
- R9: The flag is set by these events: a primary match in modes 001 to 011; a secondary match that ends a pulse in modes 100 and 101; a rollover or a new fault in modes 110 and 111. Once set, the flag stays set. A write to address 3 clears it one edge later, unless an event occurs in that same cycle, in which case the flag stays set.

Top module ports listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_a_cnt | input | 16 | Timer A count |
| tmr_a_roll | input | 1 | Timer A rollover strobe |
| tmr_b_cnt | input | 16 | Timer B count |
| tmr_b_roll | input | 1 | Timer B rollover strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register write address |
| reg_wdata | input | 16 | Register write data |
| fault_i | input | 1 | Fault input, active high |
| pin_o | output | 1 | Compare output pin |
| pin_oe_o | output | 1 | Output enable for the pin |
| flag_o | output | 1 | Sticky compare interrupt flag |

## Verification
Two functions can land in the same cycle, and the bench forces each such case on purpose. First, in PWM a rollover can arrive on a cycle where the count also equals the freshly reloaded duty value. The bench drives both at once and expects the pin to be high. Second, in the fault variant a fault can coincide with a rollover. The bench expects the pin low and the flag set. A flag acknowledge can also land on the same cycle as a new match, and the bench expects the flag to survive that cycle.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  typedef enum logic [2:0] {
    OC_OFF  = 3'd0,
    OC_SET  = 3'd1,
    OC_CLR  = 3'd2,
    OC_TGL  = 3'd3,
    OC_DLY  = 3'd4,
    OC_CONT = 3'd5,
    OC_PWM  = 3'd6,
    OC_PWMF = 3'd7
  } oc_mode_e;

  typedef enum logic [1:0] {
    RA_PRI = 2'd0,
    RA_SEC = 2'd1,
    RA_CTL = 2'd2,
    RA_ACK = 2'd3
  } oc_addr_e;

  localparam int unsigned CTL_SEL_BIT = 3;
endpackage

// File: rtl/ocmp_rstsync.sv
module ocmp_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/ocmp_regs.sv
module ocmp_regs
  import ocmp_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] pri_q,
  output logic [CW-1:0] sec_q,
  output oc_mode_e      mode_q,
  output logic          sel_q,
  output logic          ctl_load,
  output logic          flag_clr
);
  logic [CW-1:0] pri_n, sec_n;
  oc_mode_e      mode_n;
  logic          sel_n, load_n, clr_n;

  always_comb begin
    pri_n  = pri_q;
    sec_n  = sec_q;
    mode_n = mode_q;
    sel_n  = sel_q;
    load_n = 1'b0;
    clr_n  = 1'b0;
    if (wr_en) begin
      unique case (oc_addr_e'(wr_addr))
        RA_PRI: pri_n = wr_data;
        RA_SEC: sec_n = wr_data;
        RA_CTL: begin
          mode_n = oc_mode_e'(wr_data[2:0]);
          sel_n  = wr_data[CTL_SEL_BIT];
          load_n = 1'b1;
        end
        RA_ACK: clr_n = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q    <= '0;
      sec_q    <= '0;
      mode_q   <= OC_OFF;
      sel_q    <= 1'b0;
      ctl_load <= 1'b0;
      flag_clr <= 1'b0;
    end else begin
      if (wr_en) begin
        pri_q  <= pri_n;
        sec_q  <= sec_n;
        mode_q <= mode_n;
        sel_q  <= sel_n;
      end
      ctl_load <= load_n;
      flag_clr <= clr_n;
    end
  end
endmodule

// File: rtl/ocmp_tbase.sv
module ocmp_tbase #(
  parameter int unsigned CW   = 16,
  parameter int unsigned NSRC = 2
) (
  input  logic [CW-1:0] cnt_a,
  input  logic          roll_a,
  input  logic [CW-1:0] cnt_b,
  input  logic          roll_b,
  input  logic          sel,
  input  logic [CW-1:0] pri,
  input  logic [CW-1:0] sec,
  output logic [CW-1:0] cnt,
  output logic          roll,
  output logic          hit_p,
  output logic          hit_s
);
  localparam int unsigned SW = $clog2(NSRC);

  logic [CW-1:0] cnt_v  [NSRC];
  logic          roll_v [NSRC];
  logic [SW-1:0] idx;

  assign cnt_v[0]  = cnt_a;
  assign roll_v[0] = roll_a;
  assign cnt_v[1]  = cnt_b;
  assign roll_v[1] = roll_b;
  assign idx       = SW'(sel);

  assign cnt   = cnt_v[idx];
  assign roll  = roll_v[idx];
  assign hit_p = (cnt == pri);
  assign hit_s = (cnt == sec);
endmodule

// File: rtl/ocmp_core.sv
module ocmp_core
  import ocmp_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  oc_mode_e      mode,
  input  logic          ctl_load,
  input  logic          flag_clr,
  input  logic [CW-1:0] cnt,
  input  logic          roll,
  input  logic          hit_p,
  input  logic          hit_s,
  input  logic [CW-1:0] sec,
  input  logic          fault,
  output logic          pin,
  output logic          oe,
  output logic          flag
);
  logic          pin_q, pin_n, oe_q, oe_n, flag_q, flag_n;
  logic          done_q, done_n, flt_q, flt_n, ev;
  logic [CW-1:0] duty_q, duty_n;

  always_comb begin
    pin_n  = pin_q;
    oe_n   = oe_q;
    done_n = done_q;
    flt_n  = flt_q;
    duty_n = duty_q;
    ev     = 1'b0;
    if (ctl_load) begin
      pin_n  = (mode == OC_CLR);
      oe_n   = (mode != OC_OFF);
      done_n = 1'b0;
      flt_n  = 1'b0;
      duty_n = sec;
    end else begin
      unique case (mode)
        OC_SET: if (hit_p) begin pin_n = 1'b1;    ev = 1'b1; end
        OC_CLR: if (hit_p) begin pin_n = 1'b0;    ev = 1'b1; end
        OC_TGL: if (hit_p) begin pin_n = ~pin_q;  ev = 1'b1; end
        OC_DLY, OC_CONT: begin
          if (pin_q && hit_s) begin
            pin_n = 1'b0;
            ev    = 1'b1;
            if (mode == OC_DLY) done_n = 1'b1;
          end else if (!pin_q && hit_p && !done_q) begin
            pin_n = 1'b1;
          end
        end
        OC_PWM, OC_PWMF: begin
          if ((mode == OC_PWMF) && (flt_q || fault)) begin
            pin_n = 1'b0;
            flt_n = 1'b1;
            ev    = !flt_q;
          end else if (roll) begin
            duty_n = sec;
            pin_n  = (sec != '0);
            ev     = 1'b1;
          end else if (cnt == duty_q) begin
            pin_n = 1'b0;
          end
        end
        default: pin_n = 1'b0;
      endcase
    end
    flag_n = (flag_q & ~flag_clr) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      oe_q   <= 1'b0;
      flag_q <= 1'b0;
      done_q <= 1'b0;
      flt_q  <= 1'b0;
      duty_q <= '0;
    end else begin
      pin_q  <= pin_n;
      oe_q   <= oe_n;
      flag_q <= flag_n;
      done_q <= done_n;
      flt_q  <= flt_n;
      duty_q <= duty_n;
    end
  end

  assign pin  = oe_q & pin_q;
  assign oe   = oe_q;
  assign flag = flag_q;
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tmr_a_cnt,
  input  logic          tmr_a_roll,
  input  logic [CW-1:0] tmr_b_cnt,
  input  logic          tmr_b_roll,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  input  logic          fault_i,
  output logic          pin_o,
  output logic          pin_oe_o,
  output logic          flag_o
);
  logic          rst_q;
  logic [CW-1:0] pri_q, sec_q, cnt_sel;
  oc_mode_e      mode;
  logic          sel_q, ctl_load, flag_clr, roll_sel, hit_p, hit_s;

  ocmp_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  ocmp_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .pri_q(pri_q), .sec_q(sec_q), .mode_q(mode),
    .sel_q(sel_q), .ctl_load(ctl_load), .flag_clr(flag_clr)
  );

  ocmp_tbase #(.CW(CW), .NSRC(2)) u_tbase (
    .cnt_a(tmr_a_cnt), .roll_a(tmr_a_roll), .cnt_b(tmr_b_cnt),
    .roll_b(tmr_b_roll), .sel(sel_q), .pri(pri_q), .sec(sec_q),
    .cnt(cnt_sel), .roll(roll_sel), .hit_p(hit_p), .hit_s(hit_s)
  );

  ocmp_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_q), .mode(mode), .ctl_load(ctl_load),
    .flag_clr(flag_clr), .cnt(cnt_sel), .roll(roll_sel), .hit_p(hit_p),
    .hit_s(hit_s), .sec(sec_q), .fault(fault_i), .pin(pin_o),
    .oe(pin_oe_o), .flag(flag_o)
  );
endmodule

// File: rtl/ocmp_chk.sv
module ocmp_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic          ctl_load,
  input logic          flag_clr,
  input logic          hit_p,
  input logic          roll,
  input logic [CW-1:0] sec,
  input logic          fault_i,
  input logic          pin_o,
  input logic          pin_oe_o,
  input logic          flag_o
);
  a_r3_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe_o |-> !pin_o);

  a_r4_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && pin_o && !ctl_load) |=> pin_o);

  a_r4_clr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && !pin_o && !ctl_load) |=> !pin_o);

  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && hit_p && !ctl_load) |=> (pin_o != $past(pin_o)));

  a_r7_roll_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd6 && roll && sec != '0 && !ctl_load) |=> pin_o);

  a_r8_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7 && fault_i && !ctl_load) |=> !pin_o);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr) |=> flag_o);

  a_r9_toggle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && hit_p && !ctl_load) |=> flag_o);
endmodule

bind ocmp_unit ocmp_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_q), .mode(mode), .ctl_load(ctl_load),
  .flag_clr(flag_clr), .hit_p(hit_p), .roll(roll_sel), .sec(sec_q),
  .fault_i(fault_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .flag_o(flag_o)
);

// File: tb/sim_ocmp_unit.sv
module sim_ocmp_unit;
  logic        clk, rst_n;
  logic [15:0] ta_cnt, tb_cnt, wdata;
  logic        ta_roll, tb_roll, wr, fault;
  logic [1:0]  addr;
  logic        pin, oe, flag;
  int          n_chk, n_bad, cyc;

  ocmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .tmr_a_cnt(ta_cnt), .tmr_a_roll(ta_roll),
    .tmr_b_cnt(tb_cnt), .tmr_b_roll(tb_roll), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .fault_i(fault), .pin_o(pin), .pin_oe_o(oe),
    .flag_o(flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {mode[2:0], count[15:0], expected pin}; primary 10, secondary 14
  localparam logic [19:0] VEC [22] = '{
    {3'd3, 16'd5,  1'b0}, {3'd3, 16'd10, 1'b1}, {3'd3, 16'd11, 1'b1},
    {3'd3, 16'd10, 1'b0}, {3'd3, 16'd3,  1'b0}, {3'd3, 16'd10, 1'b1},
    {3'd4, 16'd10, 1'b1}, {3'd4, 16'd12, 1'b1}, {3'd4, 16'd14, 1'b0},
    {3'd4, 16'd10, 1'b0}, {3'd4, 16'd14, 1'b0},
    {3'd5, 16'd10, 1'b1}, {3'd5, 16'd14, 1'b0}, {3'd5, 16'd10, 1'b1},
    {3'd5, 16'd9,  1'b1}, {3'd5, 16'd14, 1'b0},
    {3'd1, 16'd9,  1'b0}, {3'd1, 16'd10, 1'b1}, {3'd1, 16'd3,  1'b1},
    {3'd2, 16'd9,  1'b1}, {3'd2, 16'd10, 1'b0}, {3'd2, 16'd2,  1'b0}
  };

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cyc);
      finish_run();
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0b exp=%0b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
    tick();
  endtask

  initial begin
    logic [2:0] cur;
    n_chk = 0; n_bad = 0; cyc = 0;
    rst_n = 1'b0; ta_cnt = 0; tb_cnt = 0; ta_roll = 0; tb_roll = 0;
    wr = 0; addr = 0; wdata = 0; fault = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R3 reset pin", pin, 1'b0);
    chk("R3 reset oe", oe, 1'b0);
    chk("R9 reset flag", flag, 1'b0);

    wreg(2'd0, 16'd10);
    wreg(2'd1, 16'd14);
    // R3: mode 000 ignores a match
    ta_cnt = 10; tick(); tick();
    chk("R3 off pin", pin, 1'b0);
    chk("R3 off flag", flag, 1'b0);
    ta_cnt = 0;

    cur = 3'd0;
    foreach (VEC[i]) begin
      if (VEC[i][19:17] != cur) begin
        ta_cnt = 0;
        cur = VEC[i][19:17];
        wreg(2'd2, {13'd0, cur});
        chk("R2 start level", pin, cur == 3'd2);
      end
      ta_cnt = VEC[i][16:1];
      tick();
      chk("R4/R5/R6 table", pin, VEC[i][0]);
    end
    chk("R3 oe on", oe, 1'b1);

    // R9 flag: set earlier, ack collides with a match
    ta_cnt = 0;
    wreg(2'd2, 16'h0001);
    wreg(2'd3, 16'd0);
    chk("R9 ack clears", flag, 1'b0);
    ta_cnt = 10; tick();
    chk("R9 match sets", flag, 1'b1);
    wr = 1; addr = 2'd3; tick(); wr = 0; tick();
    chk("R9 set beats ack", flag, 1'b1);
    ta_cnt = 0; tick();
    chk("R9 sticky", flag, 1'b1);

    // R1: time base B in toggle mode
    wreg(2'd2, 16'h000B);
    ta_cnt = 10; tick();
    chk("R1 other timer ignored", pin, 1'b0);
    tb_cnt = 10; tick();
    chk("R1 timer B match", pin, 1'b1);
    ta_cnt = 0; tb_cnt = 0;

    // R1 with PWM on timer B rollover
    wreg(2'd1, 16'd4);
    wreg(2'd2, 16'h000E);
    tb_cnt = 1; ta_roll = 1; tick(); ta_roll = 0;
    chk("R1 other rollover ignored", pin, 1'b0);
    tb_cnt = 0; tb_roll = 1; tick(); tb_roll = 0;
    chk("R1 timer B rollover", pin, 1'b1);
    tb_cnt = 0;

    // R7 PWM on timer A, duty 4
    wreg(2'd2, 16'h0006);
    ta_cnt = 0; ta_roll = 1; tick(); ta_roll = 0;
    chk("R7 rollover high", pin, 1'b1);
    ta_cnt = 1; wr = 1; addr = 2'd1; wdata = 16'd2; tick(); wr = 0;
    ta_cnt = 2; tick();
    chk("R7 new duty deferred", pin, 1'b1);
    ta_cnt = 4; tick();
    chk("R7 duty match low", pin, 1'b0);
    ta_cnt = 0; ta_roll = 1; tick(); ta_roll = 0;
    chk("R7 reload high", pin, 1'b1);
    ta_cnt = 2; tick();
    chk("R7 new duty low", pin, 1'b0);
    ta_roll = 1; tick(); ta_roll = 0;
    chk("R7 rollover beats match", pin, 1'b1);
    fault = 1; ta_cnt = 0; ta_roll = 1; tick(); ta_roll = 0; fault = 0;
    chk("R8 mode 110 ignores fault", pin, 1'b1);
    wreg(2'd1, 16'd0);
    ta_roll = 1; tick(); ta_roll = 0;
    chk("R7 zero duty", pin, 1'b0);
    wreg(2'd1, 16'd4);

    // R8 fault-protected PWM
    wreg(2'd2, 16'h0007);
    wreg(2'd3, 16'd0);
    ta_cnt = 0; ta_roll = 1; tick();
    chk("R8 runs before fault", pin, 1'b1);
    ta_roll = 0; wreg(2'd3, 16'd0);
    fault = 1; ta_roll = 1; tick(); fault = 0;
    chk("R8 fault beats rollover", pin, 1'b0);
    chk("R8 fault flag", flag, 1'b1);
    tick();
    chk("R8 latched", pin, 1'b0);
    ta_roll = 0;
    wreg(2'd2, 16'h0007);
    ta_roll = 1; tick(); ta_roll = 0;
    chk("R8 rewrite restarts", pin, 1'b1);

    // R2 back to off
    wreg(2'd2, 16'h0000);
    chk("R2 off oe", oe, 1'b0);
    chk("R2 off pin", pin, 1'b0);
    finish_run();
  end
endmodule